// File: doc/BRIEF.md
# Front-End Micro-Op Delivery Selector

This block sits in a processor front end between three producers of micro-ops and the instruction decode queue. The producers are the decoded-op cache, the legacy decoder and the microcode sequencer. Every cycle each producer offers a count of ready micro-ops, and the queue reports how many slots it has free. The selector picks exactly one producer and grants it a number of micro-ops. It reports the grant back to every producer, so each one knows how many of its micro-ops were taken.

Each producer has its own width cap. The microcode sequencer has top priority and owns any cycle it delivers in. A move from the cache path to the legacy path costs a fixed number of dead cycles. During those cycles no producer is served.

Four saturating totals run alongside delivery:
- micro-ops taken from the cache
- micro-ops taken from the legacy decoder
- micro-ops taken from the microcode sequencer
- dead cycles spent on path switches

Performance monitoring reads these totals.

Top module: `uop_delivery_sel`

## Requirements
- R1: The cache grant never exceeds CACHE_CAP (default 6) micro-ops in a cycle.
- R2: The legacy decoder grant never exceeds LEG_CAP (default 4) micro-ops in a cycle.
- R3: The microcode grant never exceeds UC_CAP (default 4) micro-ops in a cycle.
- R4: A producer is offering when its count input is non-zero. Only one producer is granted per cycle. A microcode offer wins over a cache offer, and a cache offer wins over a legacy offer. In a microcode cycle both other grants are zero.
- R5: The grant to the chosen producer equals the smallest of its cap, its offered count and `q_free`. `push_cnt` equals that grant.
- R6: Suppose the legacy decoder is chosen, and the last producer that received a non-zero grant was the cache. Then `switch_stall` is high for PENALTY consecutive cycles (default 2), starting with that cycle. In those cycles all grants are zero, whatever is offered and whatever `q_free` is. After the window, the legacy decoder is served without a further penalty. A microcode delivery in between the cache and the legacy decoder removes the penalty.
- R7: `stall_total` grows by one in each cycle where `switch_stall` is high.
- R8: `cache_total`, `legacy_total` and `ucode_total` each grow by their producer's grant every cycle. The new value is visible one clock edge later.
- R9: Every total stops at its all-ones value (CTR_W bits, default 32) and stays there.
- R10: A synchronous reset clears all four totals. It also forgets the last-served producer, so a legacy delivery right after reset is not penalised.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cache_cnt | input | SRC_W | Micro-ops offered by the decoded-op cache |
| legacy_cnt | input | SRC_W | Micro-ops offered by the legacy decoder |
| ucode_cnt | input | SRC_W | Micro-ops offered by the microcode sequencer |
| q_free | input | FREE_W | Free slots in the decode queue |
| cache_acc | output | SRC_W | Micro-ops taken from the cache this cycle |
| legacy_acc | output | SRC_W | Micro-ops taken from the legacy decoder this cycle |
| ucode_acc | output | SRC_W | Micro-ops taken from the microcode sequencer this cycle |
| push_cnt | output | SRC_W | Micro-ops written into the decode queue this cycle |
| switch_stall | output | 1 | Dead cycle caused by a cache-to-legacy switch |
| cache_total | output | CTR_W | Saturating total of cache deliveries |
| legacy_total | output | CTR_W | Saturating total of legacy deliveries |
| ucode_total | output | CTR_W | Saturating total of microcode deliveries |
| stall_total | output | CTR_W | Saturating total of switch dead cycles |

## Verification
Some rules are checked by assertions on every cycle:
- the per-producer caps
- the limit set by queue space
- exclusive grants in microcode cycles
- silence during a switch stall
- no legacy grant in the cycle right after a cache grant
- totals that never fall and that hold once saturated

Other behaviour needs the bench's scenarios, which compare against a reference model:
- the exact length of the dead window
- the penalty being removed by an intervening microcode delivery
- the exact grant value under each priority case
- the reset clearing the last-served producer

// File: rtl/uopsel_pkg.sv
package uopsel_pkg;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_CACHE  = 2'd1,
        SRC_LEGACY = 2'd2,
        SRC_UCODE  = 2'd3
    } src_e;

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/uopsel_arbiter.sv
module uopsel_arbiter
    import uopsel_pkg::*;
#(
    parameter int SRC_W     = 3,
    parameter int FREE_W    = 5,
    parameter int CACHE_CAP = 6,
    parameter int LEG_CAP   = 4,
    parameter int UC_CAP    = 4
) (
    input  logic [SRC_W-1:0]  cache_cnt,
    input  logic [SRC_W-1:0]  legacy_cnt,
    input  logic [SRC_W-1:0]  ucode_cnt,
    input  logic [FREE_W-1:0] q_free,
    output src_e              want,
    output logic [SRC_W-1:0]  grant
);

    int cap_sel;
    int cnt_sel;

    // Fixed priority: microcode, then cache, then legacy decoder.
    always_comb begin
        want    = SRC_NONE;
        cap_sel = 0;
        cnt_sel = 0;
        if (ucode_cnt != '0) begin
            want    = SRC_UCODE;
            cap_sel = UC_CAP;
            cnt_sel = int'(ucode_cnt);
        end else if (cache_cnt != '0) begin
            want    = SRC_CACHE;
            cap_sel = CACHE_CAP;
            cnt_sel = int'(cache_cnt);
        end else if (legacy_cnt != '0) begin
            want    = SRC_LEGACY;
            cap_sel = LEG_CAP;
            cnt_sel = int'(legacy_cnt);
        end
        grant = SRC_W'(imin(imin(cap_sel, cnt_sel), int'(q_free)));
    end

endmodule

// File: rtl/uopsel_switch_guard.sv
module uopsel_switch_guard
    import uopsel_pkg::*;
#(
    parameter int PENALTY = 2
) (
    input  logic clk,
    input  logic rst,
    input  src_e want,
    input  logic delivered,
    output logic stall
);

    localparam int PW = $clog2(PENALTY + 2);
    localparam logic [PW-1:0] RELOAD = PW'((PENALTY > 0) ? PENALTY - 1 : 0);

    typedef struct packed {
        logic [PW-1:0] left;
        src_e          last;
    } gstate_t;

    gstate_t st_d, st_q;
    logic    trigger;

    always_comb begin
        st_d    = st_q;
        trigger = (PENALTY > 0) && (st_q.left == '0) &&
                  (want == SRC_LEGACY) && (st_q.last == SRC_CACHE);
        stall   = (st_q.left != '0) || trigger;
        if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end else if (trigger) begin
            st_d.left = RELOAD;
            st_d.last = SRC_LEGACY;
        end else if (delivered) begin
            st_d.last = want;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{left: '0, last: SRC_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    // A window that is still running keeps counting down until it ends.
    AST_WINDOW_DRAINS: assert property (@(posedge clk) disable iff (rst)
        (st_q.left > PW'(1)) |=> (st_q.left == $past(st_q.left) - 1'b1)) else $error("window"); // R6

endmodule

// File: rtl/uopsel_sat_ctr.sv
module uopsel_sat_ctr #(
    parameter int CTR_W = 32,
    parameter int INC_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [INC_W-1:0] inc,
    output logic [CTR_W-1:0] cnt
);

    logic [CTR_W-1:0] cnt_d, cnt_q;
    logic [CTR_W:0]   sum;

    always_comb begin
        sum   = {1'b0, cnt_q} + (CTR_W + 1)'(inc);
        cnt_d = sum[CTR_W] ? '1 : sum[CTR_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    AST_CTR_NEVER_FALLS: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cnt_q >= $past(cnt_q))) else $error("fell"); // R8
    AST_CTR_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == '1) |=> (cnt_q == '1)) else $error("sat"); // R9

endmodule

// File: rtl/uop_delivery_sel.sv
module uop_delivery_sel
    import uopsel_pkg::*;
#(
    parameter int SRC_W     = 3,
    parameter int FREE_W    = 5,
    parameter int CACHE_CAP = 6,
    parameter int LEG_CAP   = 4,
    parameter int UC_CAP    = 4,
    parameter int PENALTY   = 2,
    parameter int CTR_W     = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SRC_W-1:0]  cache_cnt,
    input  logic [SRC_W-1:0]  legacy_cnt,
    input  logic [SRC_W-1:0]  ucode_cnt,
    input  logic [FREE_W-1:0] q_free,
    output logic [SRC_W-1:0]  cache_acc,
    output logic [SRC_W-1:0]  legacy_acc,
    output logic [SRC_W-1:0]  ucode_acc,
    output logic [SRC_W-1:0]  push_cnt,
    output logic              switch_stall,
    output logic [CTR_W-1:0]  cache_total,
    output logic [CTR_W-1:0]  legacy_total,
    output logic [CTR_W-1:0]  ucode_total,
    output logic [CTR_W-1:0]  stall_total
);

    localparam int NCTR = 4;

    src_e             want;
    logic [SRC_W-1:0] raw_grant;
    logic [SRC_W-1:0] grant;
    logic             delivered;
    logic [SRC_W-1:0] inc_arr [NCTR];
    logic [CTR_W-1:0] tot_arr [NCTR];

    uopsel_arbiter #(
        .SRC_W(SRC_W), .FREE_W(FREE_W), .CACHE_CAP(CACHE_CAP),
        .LEG_CAP(LEG_CAP), .UC_CAP(UC_CAP)
    ) u_arb (
        .cache_cnt(cache_cnt), .legacy_cnt(legacy_cnt), .ucode_cnt(ucode_cnt),
        .q_free(q_free), .want(want), .grant(raw_grant)
    );

    uopsel_switch_guard #(.PENALTY(PENALTY)) u_guard (
        .clk(clk), .rst(rst), .want(want), .delivered(delivered), .stall(switch_stall)
    );

    always_comb begin
        grant      = switch_stall ? '0 : raw_grant;
        delivered  = (grant != '0);
        cache_acc  = (want == SRC_CACHE)  ? grant : '0;
        legacy_acc = (want == SRC_LEGACY) ? grant : '0;
        ucode_acc  = (want == SRC_UCODE)  ? grant : '0;
        push_cnt   = grant;
    end

    assign inc_arr[0] = cache_acc;
    assign inc_arr[1] = legacy_acc;
    assign inc_arr[2] = ucode_acc;
    assign inc_arr[3] = {{(SRC_W-1){1'b0}}, switch_stall};

    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
        uopsel_sat_ctr #(.CTR_W(CTR_W), .INC_W(SRC_W)) u_ctr (
            .clk(clk), .rst(rst), .inc(inc_arr[g]), .cnt(tot_arr[g])
        );
    end

    assign cache_total  = tot_arr[0];
    assign legacy_total = tot_arr[1];
    assign ucode_total  = tot_arr[2];
    assign stall_total  = tot_arr[3];

    AST_CACHE_CAP: assert property (@(posedge clk) disable iff (rst)
        int'(cache_acc) <= CACHE_CAP) else $error("cache cap"); // R1
    AST_LEGACY_CAP: assert property (@(posedge clk) disable iff (rst)
        int'(legacy_acc) <= LEG_CAP) else $error("legacy cap"); // R2
    AST_UCODE_CAP: assert property (@(posedge clk) disable iff (rst)
        int'(ucode_acc) <= UC_CAP) else $error("ucode cap"); // R3
    AST_UCODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (ucode_acc != '0) |-> (cache_acc == '0 && legacy_acc == '0)) else $error("excl"); // R4
    AST_FREE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        int'(push_cnt) <= int'(q_free)) else $error("free"); // R5
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
        switch_stall |-> (cache_acc == '0 && legacy_acc == '0 && ucode_acc == '0)) else $error("quiet"); // R6
    AST_NO_DIRECT_SWITCH: assert property (@(posedge clk) disable iff (rst)
        (PENALTY > 0 && cache_acc != '0) |=> (legacy_acc == '0)) else $error("switch"); // R6

endmodule

// File: tb/tb_uop_delivery_sel.sv
module tb_uop_delivery_sel;

    localparam int SW   = 3;
    localparam int FW   = 5;
    localparam int CW   = 10;
    localparam int PEN  = 2;
    localparam longint MAXC = (64'd1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [SW-1:0] cache_cnt = '0, legacy_cnt = '0, ucode_cnt = '0;
    logic [FW-1:0] q_free = '0;
    logic [SW-1:0] cache_acc, legacy_acc, ucode_acc, push_cnt;
    logic          switch_stall;
    logic [CW-1:0] cache_total, legacy_total, ucode_total, stall_total;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    int     m_last = 0;   // 0 none, 1 cache, 2 legacy, 3 ucode
    int     m_left = 0;
    longint m_tot [4];

    always #10 clk = ~clk;

    uop_delivery_sel #(.SRC_W(SW), .FREE_W(FW), .PENALTY(PEN), .CTR_W(CW)) dut (
        .clk(clk), .rst(rst), .cache_cnt(cache_cnt), .legacy_cnt(legacy_cnt),
        .ucode_cnt(ucode_cnt), .q_free(q_free), .cache_acc(cache_acc),
        .legacy_acc(legacy_acc), .ucode_acc(ucode_acc), .push_cnt(push_cnt),
        .switch_stall(switch_stall), .cache_total(cache_total),
        .legacy_total(legacy_total), .ucode_total(ucode_total), .stall_total(stall_total)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int mn(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic check_totals(input string req);
        chk(req == "" ? "R8" : req, "cache_total",  longint'(cache_total),  m_tot[0]);
        chk(req == "" ? "R8" : req, "legacy_total", longint'(legacy_total), m_tot[1]);
        chk(req == "" ? "R8" : req, "ucode_total",  longint'(ucode_total),  m_tot[2]);
        chk(req == "" ? "R7" : req, "stall_total",  longint'(stall_total),  m_tot[3]);
    endtask

    // One cycle: check registered totals, drive, check grants, advance model.
    task automatic step(input int c, input int l, input int u, input int f, input string req);
        int want, cap, cnt, amt, stall, trig;
        @(negedge clk);
        check_totals("");
        cache_cnt = SW'(c); legacy_cnt = SW'(l); ucode_cnt = SW'(u); q_free = FW'(f);
        #2;
        want = (u != 0) ? 3 : (c != 0) ? 1 : (l != 0) ? 2 : 0;
        cap  = (want == 1) ? 6 : (want == 0) ? 0 : 4;
        cnt  = (want == 3) ? u : (want == 1) ? c : (want == 2) ? l : 0;
        amt  = mn(mn(cap, cnt), f);
        trig = (PEN > 0 && m_left == 0 && want == 2 && m_last == 1) ? 1 : 0;
        stall = (m_left != 0 || trig != 0) ? 1 : 0;
        if (stall != 0) amt = 0;
        chk(req, "cache_acc",  longint'(cache_acc),  (want == 1) ? amt : 0);
        chk(req, "legacy_acc", longint'(legacy_acc), (want == 2) ? amt : 0);
        chk(req, "ucode_acc",  longint'(ucode_acc),  (want == 3) ? amt : 0);
        chk(req, "push_cnt",   longint'(push_cnt),   amt);
        chk("R6", "switch_stall", longint'(switch_stall), stall);
        if (m_left != 0) m_left--;
        else if (trig != 0) begin m_left = PEN - 1; m_last = 2; end
        else if (amt != 0) m_last = want;
        if (want == 1) m_tot[0] = (m_tot[0] + amt > MAXC) ? MAXC : m_tot[0] + amt;
        if (want == 2) m_tot[1] = (m_tot[1] + amt > MAXC) ? MAXC : m_tot[1] + amt;
        if (want == 3) m_tot[2] = (m_tot[2] + amt > MAXC) ? MAXC : m_tot[2] + amt;
        if (stall != 0) m_tot[3] = (m_tot[3] + 1 > MAXC) ? MAXC : m_tot[3] + 1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        cache_cnt = '0; legacy_cnt = '0; ucode_cnt = '0; q_free = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_last = 0; m_left = 0;
        for (int i = 0; i < 4; i++) m_tot[i] = 0;
        check_totals("R10");
    endtask

    function automatic int rnd_cnt();
        return ($urandom_range(0, 9) < 3) ? 0 : int'($urandom_range(1, 7));
    endfunction

    initial begin
        void'($urandom(32'd2718));
        do_reset();
        chk("R10", "push_cnt after reset", longint'(push_cnt), 0);

        step(7, 0, 0, 31, "R1");   // cache capped at 6
        step(0, 7, 0, 31, "R6");   // first dead cycle
        step(0, 7, 0, 31, "R6");   // second dead cycle
        step(0, 7, 0, 31, "R2");   // legacy capped at 4
        step(0, 0, 7, 31, "R3");   // microcode capped at 4
        step(5, 5, 3, 31, "R4");   // microcode wins alone
        step(5, 5, 0, 31, "R4");   // cache beats legacy
        step(0, 0, 2, 31, "R6");   // microcode between cache and legacy
        step(0, 3, 0, 31, "R6");   // no penalty expected
        step(6, 0, 0, 2, "R5");    // limited by queue space
        step(0, 0, 5, 0, "R5");    // full queue: nothing
        step(0, 4, 0, 0, "R6");    // penalty starts even with a full queue
        step(6, 4, 0, 31, "R6");   // dead cycle ignores a cache offer
        step(0, 4, 0, 3, "R5");

        for (int i = 0; i < 3000; i++) begin
            step(rnd_cnt(), rnd_cnt(), ($urandom_range(0, 3) == 0) ? rnd_cnt() : 0,
                 int'($urandom_range(0, 8)), "R5");
        end

        step(7, 0, 0, 31, "R1");
        do_reset();
        step(0, 4, 0, 31, "R10");  // legacy right after reset is served

        for (int i = 0; i < 300; i++) step(0, 7, 0, 31, "R9");
        @(negedge clk);
        check_totals("R9");
        chk("R9", "legacy_total saturated", longint'(legacy_total), MAXC);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(64'd20 * 64'd200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule